// File: doc/BRIEF.md
# Multi-slice line-change timestamp engine

This block watches a number of input lines grouped into slices of 32 and records each change on an enabled line. The global number of a line is its slice number times 32 plus its bit position in the slice. Every input passes through a two-flop synchroniser. In each cycle, each slice compares its synchronised value with the value it held one cycle earlier, looking only at the enabled bits. A slice that shows a difference writes one entry into an event queue. The entry holds the 64-bit free-running tick count, the slice number, and the masked previous and current values of that slice. XOR of the two values gives the set of lines that moved, so edges that land in the same cycle share one entry.

Software reaches the block through 32-bit register reads and writes. It turns the engine and the interrupt on, sets a per-line enable mask for each slice, and picks an occupancy threshold. It then reads the oldest entry and removes it with a command write. A level interrupt stays high while the queue holds at least the threshold number of entries.

Top module: `slice_event_stamper`

## Requirements
- R1: After reset, control (offset 0x00) reads 0x0000_0100: engine off in bit 0, interrupt off in bit 1, threshold 1 in bits [15:8]. Status (0x20) reads 0 and `irq_o` is low.
- R2: With the engine on, a level change on an enabled line adds one entry. Source (0x0C) bits [23:16] give the slice number. Previous (0x14) and current (0x10) give the slice's enabled bits before and after the change.
- R3: A change on a line whose enable bit is clear adds no entry. Each slice's enable mask sits at 0x40 + slice*0x20 and reads back as written.
- R4: Lines of one slice that change in the same cycle share one entry. Slices that change in the same cycle are queued in ascending slice order, all with the same timestamp.
- R5: The head registers keep showing the oldest entry until a write of 1 in bit 0 of the command register (0x1C) removes it. A removal command on an empty queue changes nothing.
- R6: Status bits [15:8] give the number of entries held.
- R7: `irq_o` is high exactly when the engine is on, the interrupt is on, and the occupancy is at least the threshold.
- R8: When the queue is full, new entries are dropped and status bit 0 is set. The bit stays set until a write of 1 to bit 0 of status clears it, and the held entries are kept.
- R9: The timestamp is a 64-bit count that rises by one every clock. It is read as a high half (0x04) and a low half (0x08). Two entries detected N cycles apart differ by N.
- R10: Writing 0 to control stops capture and forces `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timestamp tick |
| rst_n | input | 1 | Active-low reset |
| lines_i | input | NSLICE*32 | Asynchronous monitored lines; bit slice*32+n is line n of that slice |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`; combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The main path is driven with a table of line patterns over two slices:
- a single rising edge, which tests the slice and the previous/current values;
- a toggle on a masked line, which must not add an entry;
- a change in the second slice only, which tests the slice number;
- several bits of one slice changing together, which must give one entry and not three;
- both slices changing in one cycle, which must give two entries in slice order with equal timestamps;
- a repeat of the same pattern, which must add nothing.

Directed sequences then test the tick spacing between entries, the interrupt threshold crossing up and down, overflow on a small queue with its sticky flag, removal from an empty queue, and the control register cleared to zero.

// File: rtl/slice_event_stamper.sv
`timescale 1ns/1ps
module slice_event_stamper #(
  parameter int NSLICE = 2,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLICE*32-1:0]   lines_i,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   irq_o
);
  localparam int LW = 32;
  localparam int NL = NSLICE * LW;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EN_BASE = 'h40;
  localparam int EN_STEP = 'h20;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_TSH  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_TSL  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_PREV = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h20);

  logic [NL-1:0] sync1, sync2, last;
  logic [LW-1:0] en_q [NSLICE];
  logic          ctl_en, ctl_ie;
  logic [7:0]    thr;
  logic [63:0]   ts;

  logic [63:0]   m_ts [DEPTH];
  logic [7:0]    m_sl [DEPTH];
  logic [LW-1:0] m_pv [DEPTH];
  logic [LW-1:0] m_cv [DEPTH];
  logic [PW-1:0] rptr, wptr;
  logic [CW-1:0] count;
  logic          ovf;

  logic [NSLICE-1:0] chg, put;
  logic [PW-1:0]     rank [NSLICE];
  logic [CW-1:0]     n_put;
  logic              drop;

  wire pop     = bus_we && bus_addr == A_CMD && bus_wdata[0] && count != '0;
  wire ovf_clr = bus_we && bus_addr == A_STAT && bus_wdata[0];
  wire hv      = count != '0;
  wire [63:0] head_ts = m_ts[rptr];

  assign irq_o = ctl_en && ctl_ie && (count >= CW'(thr) || thr > 8'(DEPTH) ? count >= CW'(thr) && thr <= 8'(DEPTH) : 1'b0);

  genvar g;
  generate
    for (g = 0; g < NSLICE; g++) begin : g_cmp
      assign chg[g] = ctl_en && |((sync2[g*LW +: LW] ^ last[g*LW +: LW]) & en_q[g]);
    end
  endgenerate

  always_comb begin
    int acc;
    int room;
    acc   = 0;
    room  = DEPTH - int'(count);
    n_put = '0;
    drop  = 1'b0;
    for (int s = 0; s < NSLICE; s++) begin
      rank[s] = PW'(acc);
      put[s]  = chg[s] && (acc < room);
      if (chg[s] && !(acc < room)) drop = 1'b1;
      if (put[s]) n_put = n_put + CW'(1);
      if (chg[s]) acc = acc + 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      last  <= '0;
      ts    <= '0;
    end else begin
      sync1 <= lines_i;
      sync2 <= sync1;
      last  <= sync2;
      ts    <= ts + 64'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      ctl_ie <= 1'b0;
      thr    <= 8'd1;
      for (int s = 0; s < NSLICE; s++) en_q[s] <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CTRL) begin
        ctl_en <= bus_wdata[0];
        ctl_ie <= bus_wdata[1];
        thr    <= bus_wdata[15:8];
      end
      for (int s = 0; s < NSLICE; s++)
        if (bus_addr == ADDR_W'(EN_BASE + s * EN_STEP)) en_q[s] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSLICE; s++) begin
      if (put[s]) begin
        m_ts[wptr + rank[s]] <= ts;
        m_sl[wptr + rank[s]] <= 8'(s);
        m_pv[wptr + rank[s]] <= last[s*LW +: LW] & en_q[s];
        m_cv[wptr + rank[s]] <= sync2[s*LW +: LW] & en_q[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      wptr  <= wptr + PW'(n_put);
      rptr  <= rptr + PW'(pop);
      count <= count + n_put - CW'(pop);
      if (drop) ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = {16'h0, thr, 6'h0, ctl_ie, ctl_en};
      A_TSH:  bus_rdata = hv ? head_ts[63:32] : '0;
      A_TSL:  bus_rdata = hv ? head_ts[31:0] : '0;
      A_SRC:  bus_rdata = hv ? {8'h0, m_sl[rptr], 16'h0} : '0;
      A_CUR:  bus_rdata = hv ? m_cv[rptr] : '0;
      A_PREV: bus_rdata = hv ? m_pv[rptr] : '0;
      A_STAT: bus_rdata = {16'h0, 8'(count), 7'h0, ovf};
      default: ;
    endcase
    for (int s = 0; s < NSLICE; s++)
      if (bus_addr == ADDR_W'(EN_BASE + s * EN_STEP)) bus_rdata = en_q[s];
  end
endmodule

module slice_event_stamper_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_o,
  input logic          ctl_en,
  input logic          ctl_ie,
  input logic [CW-1:0] count,
  input logic [CW-1:0] n_put,
  input logic          pop,
  input logic          ovf,
  input logic          ovf_clr,
  input logic [63:0]   ts,
  input logic [63:0]   head_ts
);
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  a_r7_irq_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ctl_en && ctl_ie && count != '0));
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  a_r9_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ts == $past(ts) + 64'd1);
  a_r5_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && !pop) |=> $stable(head_ts));
  a_r5_pop_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && n_put == '0) |=> count == $past(count) - CW'(1));
endmodule

bind slice_event_stamper slice_event_stamper_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .ctl_en(ctl_en), .ctl_ie(ctl_ie),
  .count(count), .n_put(n_put), .pop(pop), .ovf(ovf), .ovf_clr(ovf_clr),
  .ts(ts), .head_ts(head_ts)
);

// File: tb/sim_slice_event_stamper.sv
`timescale 1ns/1ps
module sim_slice_event_stamper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] lines = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slice_event_stamper #(.NSLICE(2), .DEPTH(4), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  // {lines, entries, first slice, first prev, first cur}
  localparam int NV = 6;
  localparam logic [137:0] VEC [NV] = '{
    {64'h0000_0000_0000_0001, 2'd1, 8'd0, 32'h0000_0000, 32'h0000_0001},
    {64'h0000_0000_0001_0001, 2'd0, 8'd0, 32'h0000_0000, 32'h0000_0000},
    {64'h0000_0001_0001_0001, 2'd1, 8'd1, 32'h0000_0000, 32'h0000_0001},
    {64'h0000_0001_0001_0006, 2'd1, 8'd0, 32'h0000_0001, 32'h0000_0006},
    {64'h8000_0000_0001_0007, 2'd2, 8'd0, 32'h0000_0006, 32'h0000_0007},
    {64'h8000_0000_0001_0007, 2'd0, 8'd0, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic drive(input logic [63:0] v);
    @(negedge clk);
    lines = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d, t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(8'h00, d); chk("R1 control reset", d, 32'h100);
    rd(8'h20, d); chk("R1 status reset", d, 0);
    chk("R1 irq reset", irq, 0);

    wr(8'h40, 32'h0000_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R3 enable slice0 readback", d, 32'h0000_FFFF);
    rd(8'h60, d); chk("R3 enable slice1 readback", d, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0000_0101);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][137:74]);
      rd(8'h20, d); chk("R6 occupancy per vector", d[15:8], VEC[i][73:72]);
      if (VEC[i][73:72] != 0) begin
        rd(8'h0C, d); chk("R2 source slice", d[23:16], VEC[i][71:64]);
        rd(8'h14, d); chk("R2 previous value", d, VEC[i][63:32]);
        rd(8'h10, d); chk("R2 current value", d, VEC[i][31:0]);
        rd(8'h08, t0);
        wr(8'h1C, 1);
      end
      if (VEC[i][73:72] == 2) begin
        rd(8'h0C, d); chk("R4 second slice in order", d[23:16], 1);
        rd(8'h14, d); chk("R4 second prev", d, 32'h0000_0001);
        rd(8'h10, d); chk("R4 second cur", d, 32'h8000_0000);
        rd(8'h08, t1); chk("R4 shared timestamp", t1, t0);
        wr(8'h1C, 1);
      end
      rd(8'h20, d); chk("R5 drained after pops", d[15:8], 0);
    end

    // R9 tick spacing and R5 head hold
    @(negedge clk); lines[0] = 1'b0;
    repeat (10) @(negedge clk); lines[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd(8'h08, t0);
    repeat (3) @(negedge clk);
    rd(8'h08, d); chk("R5 head holds without pop", d, t0);
    rd(8'h04, d); chk("R9 high half", d, 0);
    wr(8'h1C, 1);
    rd(8'h08, t1); chk("R9 ten-tick spacing", t1 - t0, 10);
    wr(8'h1C, 1);
    rd(8'h20, d); chk("R6 empty", d[15:8], 0);
    wr(8'h1C, 1);
    rd(8'h20, d); chk("R5 pop on empty ignored", d[15:8], 0);

    // R7 threshold 2
    wr(8'h00, 32'h0000_0203);
    drive(lines ^ 64'h8);
    chk("R7 irq below threshold", irq, 0);
    drive(lines ^ 64'h8);
    chk("R7 irq at threshold", irq, 1);
    wr(8'h1C, 1);
    chk("R7 irq after pop", irq, 0);
    wr(8'h1C, 1);

    // R8 overflow with depth 4
    wr(8'h00, 32'h0000_0101);
    for (int k = 0; k < 5; k++) drive(lines ^ 64'h10);
    rd(8'h20, d); chk("R8 full occupancy", d[15:8], 4);
    chk("R8 overflow flag", d[0], 1);
    rd(8'h10, d); chk("R8 oldest entry kept", d, 32'h0000_0017);
    wr(8'h20, 1);
    rd(8'h20, d); chk("R8 overflow cleared", d[0], 0);
    chk("R8 entries kept after clear", d[15:8], 4);
    for (int k = 0; k < 4; k++) wr(8'h1C, 1);

    // R10 control cleared
    wr(8'h00, 0);
    drive(lines ^ 64'h1);
    rd(8'h20, d); chk("R10 no capture when off", d[15:8], 0);
    chk("R10 irq low when off", irq, 0);
    drive(lines ^ 64'h0001_0000);
    rd(8'h20, d); chk("R3 masked line no entry", d[15:8], 0);

    finish_run();
  end
endmodule